// File: doc/BRIEF.md
# Shared Two-Port Word Memory with Collision Arbitration

This block is a clocked two-port memory of 2048 words of 16 bits. Ports A (left) and B (right) each have their own address, chip enable, output enable, two byte-lane write strobes, write data and registered read data. Both ports may work on any location in the same cycle, and a reader on one side is never blocked by a reader on the other.

When both ports are enabled on the same address and at least one of them writes, an arbiter picks one winner. The losing port sees its busy flag and its write is dropped. This happens only when the block is built as a master. Built as a slave, the block has no arbiter: it takes both busy flags from pins driven by a master, so several devices can sit side by side to form a wider word. Each port also reports a sleep flag while its chip enable is off.

Top module: `twin_port_ram`

## Requirements
- R1: Each port addresses 2048 words of 16 bits with an 11-bit address. A word written at any address, including 0 and 2047, is returned by a read of that address from either port.
- R2: Strobe `we_hi` writes bits 15:8 and strobe `we_lo` writes bits 7:0. A byte lane whose strobe is low keeps its previous value.
- R3: A port writes only while its chip enable and at least one strobe are high. Strobes raised with chip enable low leave the memory unchanged.
- R4: In master mode a port's busy output is high only when both chip enables are high, both addresses are equal and at least one port has a strobe high. Two reads of the same word raise no busy, and both return the word.
- R5: In master mode, when a collision starts, a port that was enabled on that same address in the previous cycle wins over a port newly arriving there. If neither or both were there before, port A wins. The winner stays the same for as long as the collision continues in consecutive cycles.
- R6: A port with its busy flag high does not change memory contents.
- R7: In slave mode each busy output equals its busy input and no arbitration occurs. A high busy input blocks that port's write. If both ports write the same word with neither busy, port B's lanes land last. In master mode the busy inputs are ignored.
- R8: Read valid rises one clock after a cycle with chip enable high, output enable high and both strobes low. The read data is the word stored before that clock edge.
- R9: While read valid is low, read data is all zeros.
- R10: The sleep output is high in the cycle after the port's chip enable was low, and low in the cycle after it was high.
- R11: After reset, read valid is low, read data is zero, sleep is high and, with chip enables low, busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pa_ce | input | 1 | Port A chip enable |
| pa_oe | input | 1 | Port A output enable |
| pa_we_hi | input | 1 | Port A upper byte write strobe |
| pa_we_lo | input | 1 | Port A lower byte write strobe |
| pa_addr | input | 11 | Port A word address |
| pa_wdata | input | 16 | Port A write data |
| pa_busy_in | input | 1 | Port A busy from a master (slave mode) |
| pa_busy_out | output | 1 | Port A busy flag |
| pa_rdata | output | 16 | Port A read data |
| pa_rvalid | output | 1 | Port A read data valid |
| pa_sleep | output | 1 | Port A low-power indication |
| pb_ce | input | 1 | Port B chip enable |
| pb_oe | input | 1 | Port B output enable |
| pb_we_hi | input | 1 | Port B upper byte write strobe |
| pb_we_lo | input | 1 | Port B lower byte write strobe |
| pb_addr | input | 11 | Port B word address |
| pb_wdata | input | 16 | Port B write data |
| pb_busy_in | input | 1 | Port B busy from a master (slave mode) |
| pb_busy_out | output | 1 | Port B busy flag |
| pb_rdata | output | 16 | Port B read data |
| pb_rvalid | output | 1 | Port B read data valid |
| pb_sleep | output | 1 | Port B low-power indication |

## Verification
A master and a slave instance get the same port traffic. Simultaneous writes to one word show the tie rule. A reader already parked on a word before the other side writes there shows the incumbent rule. Continued collisions show that the winner is held. Two readers on the same word show that reads never raise busy. Single-lane writes and gated strobes separate the byte masking from the enable gating. Busy pins driven high on the slave show the external block, and the same pins on the master show that it ignores them. A long phase of random traffic over four addresses then mixes all of these cases against a reference array.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;
endpackage

// File: rtl/twin_port_arb.sv
module twin_port_arb
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter bit MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_busy_in,
    input  logic              b_ce,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_busy_in,
    output logic              a_busy,
    output logic              b_busy
);
    typedef struct packed {
        owner_e            owner;
        logic              a_ce;
        logic [ADDR_W-1:0] a_addr;
        logic              b_ce;
        logic [ADDR_W-1:0] b_addr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       hit_d;
    logic       a_old_d, b_old_d;
    owner_e     win_d;

    always_comb begin
        st_d    = st_q;
        hit_d   = a_ce && b_ce && (a_addr == b_addr) && (a_wr || b_wr);
        a_old_d = st_q.a_ce && (st_q.a_addr == a_addr);
        b_old_d = st_q.b_ce && (st_q.b_addr == b_addr);
        win_d   = OWN_NONE;
        if (hit_d) begin
            if (st_q.owner != OWN_NONE) begin
                win_d = st_q.owner;
            end else if (b_old_d && !a_old_d) begin
                win_d = OWN_B;
            end else begin
                win_d = OWN_A;
            end
        end
        st_d.owner  = win_d;
        st_d.a_ce   = a_ce;
        st_d.a_addr = a_addr;
        st_d.b_ce   = b_ce;
        st_d.b_addr = b_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_busy = MASTER ? (hit_d && (win_d == OWN_B)) : a_busy_in;
    assign b_busy = MASTER ? (hit_d && (win_d == OWN_A)) : b_busy_in;

    generate
        if (MASTER) begin : g_master_chk
            assert_single_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(a_busy && b_busy));
            assert_busy_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (a_busy || b_busy) |-> (a_ce && b_ce && (a_addr == b_addr) && (a_wr || b_wr)));
            assert_owner_kept_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
                b_busy |=> (!(a_ce && b_ce && (a_addr == b_addr) && (a_wr || b_wr)) || b_busy));
            assert_owner_kept_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
                a_busy |=> (!(a_ce && b_ce && (a_addr == b_addr) && (a_wr || b_wr)) || a_busy));
        end
    endgenerate
endmodule

// File: rtl/twin_port_mem.sv
module twin_port_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic [LANES-1:0]  a_wen,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_word,
    input  logic [LANES-1:0]  b_wen,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] cells_q [DEPTH];

    assign a_word = cells_q[a_addr];
    assign b_word = cells_q[b_addr];

    // Port B is applied after port A, so B's lanes land last on a shared word.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (a_wen[l]) cells_q[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
            if (b_wen[l]) cells_q[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/twin_port_rd.sv
module twin_port_rd #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              oe,
    input  logic              wr,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              sleep
);
    typedef struct packed {
        logic              valid;
        logic              sleep;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = ce && oe && !wr;
        st_d.data  = st_d.valid ? word : '0;
        st_d.sleep = !ce;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sleep <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.data;
    assign rvalid = st_q.valid;
    assign sleep  = st_q.sleep;

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));
    assert_valid_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(ce && oe && !wr));
    assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> !sleep);
    assert_doze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> sleep);
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter bit MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pa_ce,
    input  logic              pa_oe,
    input  logic              pa_we_hi,
    input  logic              pa_we_lo,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [DATA_W-1:0] pa_wdata,
    input  logic              pa_busy_in,
    output logic              pa_busy_out,
    output logic [DATA_W-1:0] pa_rdata,
    output logic              pa_rvalid,
    output logic              pa_sleep,
    input  logic              pb_ce,
    input  logic              pb_oe,
    input  logic              pb_we_hi,
    input  logic              pb_we_lo,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [DATA_W-1:0] pb_wdata,
    input  logic              pb_busy_in,
    output logic              pb_busy_out,
    output logic [DATA_W-1:0] pb_rdata,
    output logic              pb_rvalid,
    output logic              pb_sleep
);
    localparam int LANES = 2;

    logic             a_wr, b_wr, a_busy, b_busy;
    logic [LANES-1:0] a_strobe, b_strobe, a_wen, b_wen;
    logic [DATA_W-1:0] a_word, b_word;

    assign a_strobe = {pa_we_hi, pa_we_lo};
    assign b_strobe = {pb_we_hi, pb_we_lo};
    assign a_wr     = pa_ce && (|a_strobe);
    assign b_wr     = pb_ce && (|b_strobe);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign a_wen[l] = a_wr && !a_busy && a_strobe[l];
            assign b_wen[l] = b_wr && !b_busy && b_strobe[l];
        end
    endgenerate

    twin_port_arb #(.ADDR_W(ADDR_W), .MASTER(MASTER)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .a_ce(pa_ce), .a_wr(a_wr), .a_addr(pa_addr), .a_busy_in(pa_busy_in),
        .b_ce(pb_ce), .b_wr(b_wr), .b_addr(pb_addr), .b_busy_in(pb_busy_in),
        .a_busy(a_busy), .b_busy(b_busy)
    );

    twin_port_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) mem_i (
        .clk(clk),
        .a_wen(a_wen), .a_addr(pa_addr), .a_wdata(pa_wdata), .a_word(a_word),
        .b_wen(b_wen), .b_addr(pb_addr), .b_wdata(pb_wdata), .b_word(b_word)
    );

    twin_port_rd #(.DATA_W(DATA_W)) rd_a_i (
        .clk(clk), .rst_n(rst_n), .ce(pa_ce), .oe(pa_oe), .wr(a_wr), .word(a_word),
        .rdata(pa_rdata), .rvalid(pa_rvalid), .sleep(pa_sleep)
    );

    twin_port_rd #(.DATA_W(DATA_W)) rd_b_i (
        .clk(clk), .rst_n(rst_n), .ce(pb_ce), .oe(pb_oe), .wr(b_wr), .word(b_word),
        .rdata(pb_rdata), .rvalid(pb_rvalid), .sleep(pb_sleep)
    );

    assign pa_busy_out = a_busy;
    assign pb_busy_out = b_busy;
endmodule

// File: tb/twin_port_ram_tb_top.sv
`timescale 1ns/1ps
module twin_port_ram_tb_top;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic ce, oe, wh, wl;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
    } pin_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n;

    logic a_ce, a_oe, a_wh, a_wl, b_ce, b_oe, b_wh, b_wl, sa, sb;
    logic [AW-1:0] a_ad, b_ad;
    logic [DW-1:0] a_wd, b_wd;

    logic m_a_busy, m_b_busy, m_a_v, m_b_v, m_a_sl, m_b_sl;
    logic s_a_busy, s_b_busy, s_a_v, s_b_v, s_a_sl, s_b_sl;
    logic [DW-1:0] m_a_rd, m_b_rd, s_a_rd, s_b_rd;

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pa_ce(a_ce), .pa_oe(a_oe), .pa_we_hi(a_wh), .pa_we_lo(a_wl), .pa_addr(a_ad),
        .pa_wdata(a_wd), .pa_busy_in(sa), .pa_busy_out(m_a_busy), .pa_rdata(m_a_rd),
        .pa_rvalid(m_a_v), .pa_sleep(m_a_sl),
        .pb_ce(b_ce), .pb_oe(b_oe), .pb_we_hi(b_wh), .pb_we_lo(b_wl), .pb_addr(b_ad),
        .pb_wdata(b_wd), .pb_busy_in(sb), .pb_busy_out(m_b_busy), .pb_rdata(m_b_rd),
        .pb_rvalid(m_b_v), .pb_sleep(m_b_sl)
    );

    twin_port_ram #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b0)) slave_i (
        .clk(clk), .rst_n(rst_n),
        .pa_ce(a_ce), .pa_oe(a_oe), .pa_we_hi(a_wh), .pa_we_lo(a_wl), .pa_addr(a_ad),
        .pa_wdata(a_wd), .pa_busy_in(sa), .pa_busy_out(s_a_busy), .pa_rdata(s_a_rd),
        .pa_rvalid(s_a_v), .pa_sleep(s_a_sl),
        .pb_ce(b_ce), .pb_oe(b_oe), .pb_we_hi(b_wh), .pb_we_lo(b_wl), .pb_addr(b_ad),
        .pb_wdata(b_wd), .pb_busy_in(sb), .pb_busy_out(s_b_busy), .pb_rdata(s_b_rd),
        .pb_rvalid(s_b_v), .pb_sleep(s_b_sl)
    );

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] ref_m [DEPTH];
    logic [DW-1:0] ref_s [DEPTH];

    // previous-cycle picture used by the arbitration model (R5)
    logic          mp_ace = 1'b0, mp_bce = 1'b0;
    logic [AW-1:0] mp_aad = '0, mp_bad = '0;
    logic [1:0]    mp_win = 2'd0;

    pin_t nxt_a, nxt_b;
    logic nxt_sa, nxt_sb;

    int            q_sel [$];
    logic [17:0]   q_exp [$];
    string         q_tag [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic pin_t p_idle();
        return '0;
    endfunction

    function automatic pin_t p_rd(input logic [AW-1:0] ad);
        pin_t p = '0;
        p.ce = 1'b1; p.oe = 1'b1; p.addr = ad;
        return p;
    endfunction

    function automatic pin_t p_wr(input logic [AW-1:0] ad, input logic [DW-1:0] d,
                                  input logic hi, input logic lo);
        pin_t p = '0;
        p.ce = 1'b1; p.wh = hi; p.wl = lo; p.addr = ad; p.wd = d;
        return p;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input pin_t p);
        logic [DW-1:0] r = old;
        if (p.wh) r[15:8] = p.wd[15:8];
        if (p.wl) r[7:0]  = p.wd[7:0];
        return r;
    endfunction

    function automatic logic [17:0] rd_exp(input pin_t p, input logic [DW-1:0] word);
        logic ev = p.ce && p.oe && !(p.wh || p.wl);
        return {ev, !p.ce, ev ? word : 16'h0000};
    endfunction

    task automatic push(input int sel, input logic [17:0] e, input string tag);
        q_sel.push_back(sel);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // driver: applies one cycle of stimulus, checks busy, queues read results
    task automatic step(input string tag);
        pin_t pa, pb;
        logic aw, bw, coll, a_old, b_old, eba, ebb;
        logic [1:0] win;
        @(negedge clk);
        pa = nxt_a; pb = nxt_b;
        a_ce = pa.ce; a_oe = pa.oe; a_wh = pa.wh; a_wl = pa.wl; a_ad = pa.addr; a_wd = pa.wd;
        b_ce = pb.ce; b_oe = pb.oe; b_wh = pb.wh; b_wl = pb.wl; b_ad = pb.addr; b_wd = pb.wd;
        sa = nxt_sa; sb = nxt_sb;
        #1;
        aw = pa.ce && (pa.wh || pa.wl);
        bw = pb.ce && (pb.wh || pb.wl);
        coll = pa.ce && pb.ce && (pa.addr == pb.addr) && (aw || bw);
        a_old = mp_ace && (mp_aad == pa.addr);
        b_old = mp_bce && (mp_bad == pb.addr);
        win = 2'd0;
        if (coll) begin
            if (mp_win != 2'd0) win = mp_win;
            else if (b_old && !a_old) win = 2'd2;
            else win = 2'd1;
        end
        eba = coll && (win == 2'd2);
        ebb = coll && (win == 2'd1);
        check({tag, " R4/R5 master busy"}, {30'd0, m_a_busy, m_b_busy}, {30'd0, eba, ebb});
        check({tag, " R7 slave busy"}, {30'd0, s_a_busy, s_b_busy}, {30'd0, sa, sb});
        push(0, rd_exp(pa, ref_m[pa.addr]), {tag, " R8 master A"});
        push(1, rd_exp(pb, ref_m[pb.addr]), {tag, " R8 master B"});
        push(2, rd_exp(pa, ref_s[pa.addr]), {tag, " R8 slave A"});
        push(3, rd_exp(pb, ref_s[pb.addr]), {tag, " R8 slave B"});
        // R6: a busy port writes nothing
        if (aw && !eba) ref_m[pa.addr] = merge(ref_m[pa.addr], pa);
        if (bw && !ebb) ref_m[pb.addr] = merge(ref_m[pb.addr], pb);
        if (aw && !sa)  ref_s[pa.addr] = merge(ref_s[pa.addr], pa);
        if (bw && !sb)  ref_s[pb.addr] = merge(ref_s[pb.addr], pb);
        mp_ace = pa.ce; mp_aad = pa.addr;
        mp_bce = pb.ce; mp_bad = pb.addr;
        mp_win = win;
    endtask

    // monitor: pops the expected read results after each edge
    always @(posedge clk) begin
        int sel;
        logic [17:0] e, act;
        string tag;
        #1;
        while (q_sel.size() > 0) begin
            sel = q_sel.pop_front();
            e   = q_exp.pop_front();
            tag = q_tag.pop_front();
            case (sel)
                0: act = {m_a_v, m_a_sl, m_a_rd};
                1: act = {m_b_v, m_b_sl, m_b_rd};
                2: act = {s_a_v, s_a_sl, s_a_rd};
                default: act = {s_b_v, s_b_sl, s_b_rd};
            endcase
            check({tag, " R9 R10 read"}, {14'd0, act}, {14'd0, e});
        end
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        nxt_a = p_idle(); nxt_b = p_idle(); nxt_sa = 1'b0; nxt_sb = 1'b0;
        a_ce = 0; a_oe = 0; a_wh = 0; a_wl = 0; a_ad = '0; a_wd = '0;
        b_ce = 0; b_oe = 0; b_wh = 0; b_wl = 0; b_ad = '0; b_wd = '0;
        sa = 0; sb = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 master reset", {12'd0, m_a_v, m_a_sl, m_a_busy, m_b_v, m_b_sl, m_b_busy, m_a_rd | m_b_rd},
              {12'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0});
        check("R11 slave reset", {12'd0, s_a_v, s_a_sl, s_a_busy, s_b_v, s_b_sl, s_b_busy, s_a_rd | s_b_rd},
              {12'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0});
        rst_n = 1'b1;

        // R1 fill every word through both ports
        for (int i = 0; i < DEPTH / 2; i++) begin
            nxt_a = p_wr(AW'(i), 16'(i * 40503) ^ 16'h5A5A, 1'b1, 1'b1);
            nxt_b = p_wr(AW'(i + DEPTH / 2), 16'((i + DEPTH / 2) * 40503) ^ 16'h5A5A, 1'b1, 1'b1);
            step("R1 fill");
        end

        nxt_a = p_wr(11'd5, 16'h1234, 1'b1, 1'b1); nxt_b = p_idle(); step("R1 write");
        nxt_a = p_rd(11'd5); nxt_b = p_rd(11'd5); step("R1 R4 shared read");
        nxt_a = p_wr(11'd5, 16'hABCD, 1'b1, 1'b0); nxt_b = p_idle(); step("R2 upper lane");
        nxt_a = p_rd(11'd5); step("R2 readback");
        nxt_a = p_wr(11'd5, 16'h77EE, 1'b0, 1'b1); step("R2 lower lane");
        nxt_a = p_idle(); nxt_b = p_rd(11'd5); step("R2 readback B");

        nxt_a = p_wr(11'd6, 16'hFFFF, 1'b1, 1'b1); nxt_a.ce = 1'b0; nxt_b = p_idle();
        step("R3 gated strobe");
        nxt_a = p_rd(11'd6); step("R3 readback");

        nxt_a = p_rd(11'd7); nxt_b = p_rd(11'd7); step("R4 same word reads");

        nxt_a = p_wr(11'd8, 16'h1111, 1'b1, 1'b1); nxt_b = p_wr(11'd8, 16'h2222, 1'b1, 1'b1);
        step("R5 R6 tie");
        nxt_a = p_rd(11'd8); nxt_b = p_idle(); step("R6 tie readback");

        nxt_a = p_rd(11'd9); nxt_b = p_idle(); step("R5 A parks");
        nxt_b = p_wr(11'd9, 16'h3333, 1'b1, 1'b1); step("R5 A incumbent");
        step("R5 A held");
        nxt_a = p_idle(); nxt_b = p_rd(11'd9); step("R6 B blocked readback");

        nxt_a = p_idle(); nxt_b = p_rd(11'd10); step("R5 B parks");
        nxt_a = p_wr(11'd10, 16'h4444, 1'b1, 1'b1); step("R5 B incumbent");
        nxt_b = p_idle(); step("R5 A proceeds");
        nxt_a = p_rd(11'd10); step("R6 readback");

        nxt_a = p_wr(11'd2047, 16'h7FFF, 1'b1, 1'b1); nxt_b = p_wr(11'd0, 16'h8001, 1'b1, 1'b1);
        step("R1 boundary write");
        nxt_a = p_rd(11'd0); nxt_b = p_rd(11'd2047); step("R1 boundary read");

        nxt_sa = 1'b1; nxt_sb = 1'b1;
        nxt_a = p_wr(11'd30, 16'h5555, 1'b1, 1'b1); nxt_b = p_wr(11'd31, 16'h6666, 1'b1, 1'b1);
        step("R7 busy inputs high");
        nxt_sa = 1'b0; nxt_sb = 1'b0;
        nxt_a = p_rd(11'd30); nxt_b = p_rd(11'd31); step("R7 readback");
        nxt_a = p_wr(11'd32, 16'h0A0A, 1'b1, 1'b1); nxt_b = p_wr(11'd32, 16'h0B0B, 1'b1, 1'b1);
        step("R7 R5 shared word write");
        nxt_a = p_rd(11'd32); nxt_b = p_idle(); step("R7 shared word readback");

        nxt_a = p_wr(11'd40, 16'h1357, 1'b1, 1'b1); nxt_a.oe = 1'b1;
        nxt_b = p_rd(11'd40); nxt_b.oe = 1'b0; step("R8 R9 gated reads");
        nxt_a = p_idle(); nxt_b = p_rd(11'd40); step("R10 sleep split");
        nxt_b = p_idle(); step("R10 both asleep");

        // mixed traffic over four words
        for (int k = 0; k < 400; k++) begin
            nxt_a = p_idle(); nxt_b = p_idle();
            nxt_a.ce = ($urandom_range(0, 3) != 0);
            nxt_a.oe = $urandom_range(0, 1) != 0;
            nxt_a.wh = ($urandom_range(0, 2) == 0);
            nxt_a.wl = ($urandom_range(0, 2) == 0);
            nxt_a.addr = AW'($urandom_range(0, 3));
            nxt_a.wd = 16'($urandom);
            nxt_b.ce = ($urandom_range(0, 3) != 0);
            nxt_b.oe = $urandom_range(0, 1) != 0;
            nxt_b.wh = ($urandom_range(0, 2) == 0);
            nxt_b.wl = ($urandom_range(0, 2) == 0);
            nxt_b.addr = AW'($urandom_range(0, 3));
            nxt_b.wd = 16'($urandom);
            nxt_sa = ($urandom_range(0, 4) == 0);
            nxt_sb = ($urandom_range(0, 4) == 0);
            step("R4 R5 R6 R7 mixed");
        end
        nxt_a = p_idle(); nxt_b = p_idle(); nxt_sa = 1'b0; nxt_sb = 1'b0;
        step("R10 drain");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule